// File: doc/BRIEF.md
# Dual-Law Serial Clock Rate Generator

This block turns a fast module clock into the timing pulses that a serial shift engine needs to make its serial clock. A 13-bit rate word picks one of two ways to divide the clock. A select bit chooses between a power-of-two law, which is driven by a 4-bit exponent, and a linear law, which is driven by an 8-bit value. The block emits a one-cycle toggle pulse at every half period of the serial clock. It also emits a tick pulse on each rising half, and a level output with 50% duty that follows the serial clock the shift engine produces.

While the run input is low, the block holds its half-period counter at the reload value and keeps the level output low. A change to the rate word while the block is running restarts the divider from that reload state. The shift engine therefore never sees a short or stretched half period that mixes the old rate with the new one. Choosing the best divider value for a target frequency is left to software.

Top module: `spi_rate_gen`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released with run low, toggle, tick and sclk_ref are all 0.
- R2: With rate_word[12] = 0 (power-of-two law) and exponent E = rate_word[11:8] >= 1, the half period is 2^(E-1) module clock cycles, so the full period is 2^E. rate_word[7:0] has no effect in this law.
- R3: The smallest division is 2. In the power-of-two law, E = 0 gives the same timing as E = 1, which is a half period of one cycle.
- R4: With rate_word[12] = 1 (linear law) and N = rate_word[7:0], the half period is N+1 cycles, so the full period is 2(N+1). rate_word[11:8] has no effect in this law.
- R5: Take the first rising clock edge at which run is sampled high with a stable rate word as edge 1, and let H be the half period. The toggle output is high for exactly one cycle after edges H, 2H, 3H and so on, and is low otherwise.
- R6: sclk_ref is 0 while idle and inverts with every toggle pulse, so it is high after edges H through 2H-1, low over the next H, and so on (50% duty).
- R7: tick is high only with toggle pulses that drive sclk_ref from 0 to 1, which are the odd-numbered toggles.
- R8: One edge after run is sampled low, sclk_ref, toggle and tick are 0 and they stay 0. When run returns high, timing restarts as in R5.
- R9: If run is high and the rate word differs from the word seen at the previous edge, the outputs are 0 after that edge. Counting then restarts under the new word as in R5, with the following edge as edge 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run | input | 1 | Divider enable; low holds the divider idle |
| rate_word | input | 13 | [12] law select (0 power-of-two, 1 linear), [11:8] exponent, [7:0] linear value |
| toggle | output | 1 | One-cycle pulse at each half period of the serial clock |
| tick | output | 1 | One-cycle pulse when the serial clock level rises |
| sclk_ref | output | 1 | 50% duty reference level of the serial clock |

## Verification
The bench sweeps the power-of-two exponent from 0 to 12 and the linear value from 0 to 31, plus 255. Each setting is checked over four half periods, one cycle at a time, against a toggle, tick and level pattern computed from the half period. The sweep separates the two laws and the off-by-one at E = 0 versus E = 1. Every setting also loads junk into the field the active law does not use, which shows whether that field leaks into the count. Separate sequences drop run in the middle of a half period and change the rate word while the block is running, to show that the counter reloads instead of carrying over a partial count.

// File: rtl/spi_rate_pkg.sv
package spi_rate_pkg;

    typedef enum logic {
        DIV_POW2   = 1'b0,
        DIV_LINEAR = 1'b1
    } div_mode_e;

endpackage

// File: rtl/spi_rate_decode.sv
module spi_rate_decode
    import spi_rate_pkg::*;
#(
    parameter int EXP_W = 4,
    parameter int LIN_W = 8
) (
    input  logic [EXP_W+LIN_W:0]  word_i,
    output logic [((2**EXP_W-2) > LIN_W ? (2**EXP_W-2) : LIN_W)-1:0] half_m1_o
);
    localparam int WORD_W = 1 + EXP_W + LIN_W;
    localparam int CW     = ((2**EXP_W - 2) > LIN_W) ? (2**EXP_W - 2) : LIN_W;

    div_mode_e        mode;
    logic [EXP_W-1:0] exp_f;
    logic [LIN_W-1:0] lin_f;
    logic [CW-1:0]    pow_m1;
    logic [CW-1:0]    lin_m1;

    assign mode  = div_mode_e'(word_i[WORD_W-1]);
    assign exp_f = word_i[LIN_W +: EXP_W];
    assign lin_f = word_i[LIN_W-1:0];

    // Power-of-two reload: (E-1) low ones; E of 0 and 1 both give 0 (divide by 2).
    for (genvar g = 0; g < CW; g++) begin : g_pow_mask
        assign pow_m1[g] = ({1'b0, exp_f} > (EXP_W+1)'(g + 1));
    end

    assign lin_m1 = CW'(lin_f);

    always_comb begin
        half_m1_o = (mode == DIV_LINEAR) ? lin_m1 : pow_m1;
    end

endmodule

// File: rtl/spi_rate_counter.sv
module spi_rate_counter #(
    parameter int EXP_W = 4,
    parameter int LIN_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  run_i,
    input  logic [EXP_W+LIN_W:0]  word_i,
    input  logic [((2**EXP_W-2) > LIN_W ? (2**EXP_W-2) : LIN_W)-1:0] half_m1_i,
    output logic                  toggle_o,
    output logic                  tick_o,
    output logic                  lvl_o
);
    localparam int WORD_W = 1 + EXP_W + LIN_W;
    localparam int CW     = ((2**EXP_W - 2) > LIN_W) ? (2**EXP_W - 2) : LIN_W;

    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic [CW-1:0]     cnt;
        logic              lvl;
        logic              tgl;
        logic              tck;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.tgl  = 1'b0;
        st_d.tck  = 1'b0;
        st_d.word = word_i;
        if (!run_i || (word_i != st_q.word)) begin
            st_d.cnt = half_m1_i;
            st_d.lvl = 1'b0;
        end else if (st_q.cnt == '0) begin
            st_d.cnt = half_m1_i;
            st_d.lvl = ~st_q.lvl;
            st_d.tgl = 1'b1;
            st_d.tck = ~st_q.lvl;
        end else begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign toggle_o = st_q.tgl;
    assign tick_o   = st_q.tck;
    assign lvl_o    = st_q.lvl;

    assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> (!lvl_o && !toggle_o && !tick_o));

    assert_restart_on_change_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && (word_i != st_q.word)) |=> (!lvl_o && !toggle_o));

    assert_count_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && (word_i == st_q.word)) |-> (st_q.cnt <= half_m1_i));

    assert_toggle_flips_R6: assert property (@(posedge clk) disable iff (!rst_n)
        toggle_o |-> (lvl_o != $past(lvl_o)));

    assert_tick_on_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |-> (toggle_o && lvl_o));

endmodule

// File: rtl/spi_rate_gen.sv
module spi_rate_gen #(
    parameter int EXP_W = 4,
    parameter int LIN_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 run,
    input  logic [EXP_W+LIN_W:0] rate_word,
    output logic                 toggle,
    output logic                 tick,
    output logic                 sclk_ref
);
    localparam int CW = ((2**EXP_W - 2) > LIN_W) ? (2**EXP_W - 2) : LIN_W;

    logic [CW-1:0] half_m1;

    spi_rate_decode #(.EXP_W(EXP_W), .LIN_W(LIN_W)) u_decode (
        .word_i    (rate_word),
        .half_m1_o (half_m1)
    );

    spi_rate_counter #(.EXP_W(EXP_W), .LIN_W(LIN_W)) u_counter (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (run),
        .word_i    (rate_word),
        .half_m1_i (half_m1),
        .toggle_o  (toggle),
        .tick_o    (tick),
        .lvl_o     (sclk_ref)
    );

endmodule

// File: tb/spi_rate_gen_test.sv
module spi_rate_gen_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run = 1'b0;
    logic [12:0] rate_word = '0;
    logic        toggle, tick, sclk_ref;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    spi_rate_gen uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .rate_word (rate_word),
        .toggle    (toggle),
        .tick      (tick),
        .sclk_ref  (sclk_ref)
    );

    task automatic check(input logic [2:0] exp_v, input string tag);
        logic [2:0] act;
        act = {toggle, tick, sclk_ref};
        total++;
        if (act !== exp_v) begin
            bad++;
            $display("FAIL %s: {toggle,tick,sclk_ref} got %b expected %b", tag, act, exp_v);
        end
    endtask

    function automatic int half_of(input logic [12:0] w);
        int e;
        if (w[12]) return int'(w[7:0]) + 1;
        e = int'(w[11:8]);
        if (e <= 1) return 1;
        return 1 << (e - 1);
    endfunction

    // Checks 4*H cycles starting with the sample after edge 1 (R5, R6, R7).
    task automatic run_pattern(input logic [12:0] w, input int ncyc, input string tag);
        int h;
        h = half_of(w);
        for (int j = 1; j <= ncyc; j++) begin
            logic t, l;
            @(negedge clk);
            t = ((j % h) == 0);
            l = (((j / h) % 2) == 1);
            check({t, t && l, l}, $sformatf("%s R5/R6/R7 word=%h j=%0d", tag, w, j));
        end
    endtask

    task automatic start(input logic [12:0] w);
        @(negedge clk);
        run = 1'b0;
        rate_word = w;
        @(negedge clk);
        check(3'b000, "R6 idle before run");
        run = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(3'b000, "R1 during reset");
        rst_n = 1'b1;
        @(negedge clk);
        check(3'b000, "R1 after reset release");

        // Power-of-two law with junk in the linear field (R2, R3).
        for (int e = 0; e <= 12; e++) begin
            logic [12:0] w;
            w = {1'b0, 4'(e), 8'((e * 37 + 5) % 256)};
            start(w);
            run_pattern(w, 4 * half_of(w), (e <= 1) ? "R3 pow2" : "R2 pow2");
        end

        // Linear law with junk in the exponent field (R4).
        for (int n = 0; n <= 32; n++) begin
            logic [12:0] w;
            w = {1'b1, 4'((n * 7 + 3) % 16), (n == 32) ? 8'd255 : 8'(n)};
            start(w);
            run_pattern(w, 4 * half_of(w), "R4 linear");
        end

        // Run drop in mid half period, then restart (R8).
        start({1'b1, 4'd0, 8'd2});
        run_pattern({1'b1, 4'd0, 8'd2}, 7, "R8 pre-drop");
        run = 1'b0;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            check(3'b000, "R8 idle after run low");
        end
        run = 1'b1;
        run_pattern({1'b1, 4'd0, 8'd2}, 12, "R8 restart");

        // Rate word change while running (R9).
        start({1'b1, 4'd5, 8'd3});
        run_pattern({1'b1, 4'd5, 8'd3}, 6, "R9 pre-change");
        rate_word = {1'b0, 4'd2, 8'd3};
        @(negedge clk);
        check(3'b000, "R9 reload on word change");
        run_pattern({1'b0, 4'd2, 8'd3}, 8, "R9 new word");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule